// File: doc/BRIEF.md
# Paired-Channel Complex Filter Combiner

This block sits after a bank of six real-coefficient channel filters and turns pairs of them into complex-coefficient filters. Within a pair, the lower-numbered channel carries data filtered with the real part of the coefficient set. The upper-numbered channel carries the same data filtered with the imaginary part. A cross add/subtract of the two channels' I and Q outputs produces the complex-coefficient result.

A 3-bit mode word sets two things: how many of the pairs (0,1), (2,3) and (4,5) are merged, and whether merged pairs use complex or biphase completion. Each merged result leaves on the lower stream of its pair. The upper stream is flagged in a bypass mask so that the gain-control stage that follows can skip it. Streams outside a merged pair pass straight through. Every output is registered once.

Top module: `cplx_pair_combiner`

## Requirements
- R1: While reset is held, and for the two clock edges after it is released, all `out_vld`, `out_sat` and `bypass_mask` bits are 0 and all output data are 0.
- R2: When the mode word's low two bits are 00 (words 000 and 100), no pair is merged. Every stream k drives, one cycle later, its own I/Q input on `out_i`/`out_q` and its own valid on `out_vld[k]`. `bypass_mask` is then all zero.
- R3: The mode word's low two bits give the number of merged pairs, taken from the lowest pair upward: 01 merges pair (0,1), 10 merges pairs (0,1) and (2,3), and 11 merges all three pairs. Stream k occupies bits [k*DW +: DW] of each data bus.
- R4: With mode bit 2 at 0, a merged pair p outputs on stream 2p the value I = I(2p) − Q(2p+1) and the value Q = I(2p+1) + Q(2p).
- R5: With mode bit 2 at 1 (biphase), a merged pair p outputs I = I(2p) and Q = I(2p+1) on stream 2p, with no arithmetic and no saturation flag.
- R6: In complex mode each result is formed one bit wider and clamped to the range [−2^(DW−1), 2^(DW−1)−1]. `out_sat[2p]` is 1 when the I or the Q result was clamped. `out_sat` is 0 for every stream that is passed through or in biphase mode.
- R7: The valid output of a merged pair's lower stream is the AND of both input valids. An output stream's data registers load only when that stream's valid is 1, and they hold their value otherwise.
- R8: For each merged pair p, `bypass_mask[2p+1]` is 1, `out_vld[2p+1]` is 0 and `out_sat[2p+1]` is 0. `bypass_mask` bits of even streams are always 0.
- R9: Latency is exactly one clock. A change of the mode word takes effect on the output of the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_word | input | 3 | Bit 2: biphase select; bits 1:0: number of merged pairs |
| in_vld | input | NCH | Per-channel input valid |
| in_i | input | NCH*DW | Per-channel in-phase data, signed, stream k at [k*DW +: DW] |
| in_q | input | NCH*DW | Per-channel quadrature data, signed, same packing |
| out_vld | output | NCH | Per-stream output valid |
| out_i | output | NCH*DW | Per-stream in-phase result |
| out_q | output | NCH*DW | Per-stream quadrature result |
| out_sat | output | NCH | Per-stream clamp flag |
| bypass_mask | output | NCH | 1 marks an upper stream absorbed into a merged pair |

## Verification
The assertions check the following on every cycle:
- a raised clamp flag always comes with a valid output that sits at a full-scale value;
- no output valid appears without its own input valid on the cycle before;
- absorbed upper streams stay silent, and even streams never show a bypass bit;
- words with low bits 00 give an empty mask;
- biphase mode never clamps.

The arithmetic values of the cross add/subtract, the order in which pairs are enabled, the hold of data across invalid cycles, and mode changes from one cycle to the next are shown only by the bench's scenarios. The bench compares these against its own model of the sums.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [0:0] {
    CPC_COMPLEX = 1'b0,
    CPC_BIPHASE = 1'b1
  } pair_mode_e;

  // number of merged pairs requested by a mode word
  function automatic int unsigned merged_pairs(input logic [2:0] word);
    return int'(word[1:0]);
  endfunction

endpackage

// File: rtl/cpc_mode_decode.sv
module cpc_mode_decode
  import cpc_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic [2:0]       mode_word,
  output logic [NPAIR-1:0] pair_en,
  output pair_mode_e       pmode
);

  int unsigned npairs;

  always_comb begin
    npairs = merged_pairs(mode_word);
    for (int p = 0; p < NPAIR; p++) begin
      pair_en[p] = (p < int'(npairs));
    end
    pmode = mode_word[2] ? CPC_BIPHASE : CPC_COMPLEX;
  end

endmodule

// File: rtl/cpc_sat_addsub.sv
module cpc_sat_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          do_sub,
  output logic [DW-1:0] res,
  output logic          clamped
);

  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0] ext_a;
  logic [DW:0] ext_b;
  logic [DW:0] wide;

  always_comb begin
    ext_a   = {op_a[DW-1], op_a};
    ext_b   = {op_b[DW-1], op_b};
    wide    = do_sub ? (ext_a - ext_b) : (ext_a + ext_b);
    clamped = (wide[DW] != wide[DW-1]);
    if (clamped) begin
      res = wide[DW] ? MINV : MAXV;
    end else begin
      res = wide[DW-1:0];
    end
  end

endmodule

// File: rtl/cpc_pair_unit.sv
module cpc_pair_unit
  import cpc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] lo_q,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] hi_q,
  input  pair_mode_e    pmode,
  output logic [DW-1:0] cmb_i,
  output logic [DW-1:0] cmb_q,
  output logic          cmb_sat
);

  logic [DW-1:0] cx_i;
  logic [DW-1:0] cx_q;
  logic          sat_i;
  logic          sat_q;

  // real part: lower-I minus upper-Q
  cpc_sat_addsub #(.DW(DW)) u_re (
    .op_a    (lo_i),
    .op_b    (hi_q),
    .do_sub  (1'b1),
    .res     (cx_i),
    .clamped (sat_i)
  );

  // imaginary part: upper-I plus lower-Q
  cpc_sat_addsub #(.DW(DW)) u_im (
    .op_a    (hi_i),
    .op_b    (lo_q),
    .do_sub  (1'b0),
    .res     (cx_q),
    .clamped (sat_q)
  );

  always_comb begin
    if (pmode == CPC_BIPHASE) begin
      cmb_i   = lo_i;
      cmb_q   = hi_i;
      cmb_sat = 1'b0;
    end else begin
      cmb_i   = cx_i;
      cmb_q   = cx_q;
      cmb_sat = sat_i | sat_q;
    end
  end

endmodule

// File: rtl/cplx_pair_combiner.sv
module cplx_pair_combiner
  import cpc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_word,
  input  logic [NCH-1:0]    in_vld,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  output logic [NCH-1:0]    out_vld,
  output logic [NCH*DW-1:0] out_i,
  output logic [NCH*DW-1:0] out_q,
  output logic [NCH-1:0]    out_sat,
  output logic [NCH-1:0]    bypass_mask
);

  localparam int NPAIR = NCH / 2;

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  // mode decode
  logic [NPAIR-1:0] pair_en;
  pair_mode_e       pmode;

  cpc_mode_decode #(.NPAIR(NPAIR)) u_dec (
    .mode_word (mode_word),
    .pair_en   (pair_en),
    .pmode     (pmode)
  );

  // per-pair arithmetic
  logic [DW-1:0] cmb_i   [NPAIR];
  logic [DW-1:0] cmb_q   [NPAIR];
  logic          cmb_sat [NPAIR];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    cpc_pair_unit #(.DW(DW)) u_pair (
      .lo_i    (in_i[(2*p)*DW +: DW]),
      .lo_q    (in_q[(2*p)*DW +: DW]),
      .hi_i    (in_i[(2*p+1)*DW +: DW]),
      .hi_q    (in_q[(2*p+1)*DW +: DW]),
      .pmode   (pmode),
      .cmb_i   (cmb_i[p]),
      .cmb_q   (cmb_q[p]),
      .cmb_sat (cmb_sat[p])
    );
  end

  // next-state selection
  logic [NCH-1:0] nxt_vld;
  logic [NCH-1:0] nxt_sat;
  logic [NCH-1:0] nxt_mask;
  logic [DW-1:0]  nxt_i [NCH];
  logic [DW-1:0]  nxt_q [NCH];

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      nxt_vld[k]  = in_vld[k];
      nxt_sat[k]  = 1'b0;
      nxt_mask[k] = 1'b0;
      nxt_i[k]    = in_i[k*DW +: DW];
      nxt_q[k]    = in_q[k*DW +: DW];
    end
    for (int p = 0; p < NPAIR; p++) begin
      if (pair_en[p]) begin
        nxt_vld[2*p]    = in_vld[2*p] & in_vld[2*p+1];
        nxt_i[2*p]      = cmb_i[p];
        nxt_q[2*p]      = cmb_q[p];
        nxt_sat[2*p]    = cmb_sat[p] & in_vld[2*p] & in_vld[2*p+1];
        nxt_vld[2*p+1]  = 1'b0;
        nxt_mask[2*p+1] = 1'b1;
      end
    end
  end

  // registers
  logic [NCH-1:0] vld_q;
  logic [NCH-1:0] sat_q;
  logic [NCH-1:0] mask_q;
  logic [DW-1:0]  dat_i_q [NCH];
  logic [DW-1:0]  dat_q_q [NCH];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= '0;
      sat_q  <= '0;
      mask_q <= '0;
    end else begin
      vld_q  <= nxt_vld;
      sat_q  <= nxt_sat;
      mask_q <= nxt_mask;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_dreg
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        dat_i_q[k] <= '0;
        dat_q_q[k] <= '0;
      end else if (nxt_vld[k]) begin
        dat_i_q[k] <= nxt_i[k];
        dat_q_q[k] <= nxt_q[k];
      end
    end
    assign out_i[k*DW +: DW] = dat_i_q[k];
    assign out_q[k*DW +: DW] = dat_q_q[k];
  end

  assign out_vld     = vld_q;
  assign out_sat     = sat_q;
  assign bypass_mask = mask_q;

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int DW  = 16,
  parameter int NCH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_word,
  input logic [NCH-1:0]    in_vld,
  input logic [NCH-1:0]    out_vld,
  input logic [NCH*DW-1:0] out_i,
  input logic [NCH*DW-1:0] out_q,
  input logic [NCH-1:0]    out_sat,
  input logic [NCH-1:0]    bypass_mask
);

  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  // R2: no merge requested -> empty bypass mask
  a_r2_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_word[1:0]) == 2'b00) |-> (bypass_mask == '0));

  // R5: biphase never clamps
  a_r5_biphase_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_word[2])) |-> (out_sat == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R7: an output valid needs its own input valid one cycle earlier
    a_r7_vld_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[k] |-> $past(in_vld[k]));

    // R6: clamp flag only on a valid, full-scale output
    a_r6_sat_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
      out_sat[k] |-> (out_vld[k] &&
        (out_i[k*DW +: DW] == MAXV || out_i[k*DW +: DW] == MINV ||
         out_q[k*DW +: DW] == MAXV || out_q[k*DW +: DW] == MINV)));

    if ((k % 2) == 1) begin : g_up
      // R8: absorbed upper stream stays silent
      a_r8_upper_silent: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_mask[k] |-> (!out_vld[k] && !out_sat[k]));
    end else begin : g_lo
      // R8: even streams are never bypassed
      a_r8_even_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_mask[k]);
    end
  end

endmodule

bind cplx_pair_combiner cpc_checker #(.DW(DW), .NCH(NCH)) u_cpc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_word   (mode_word),
  .in_vld      (in_vld),
  .out_vld     (out_vld),
  .out_i       (out_i),
  .out_q       (out_q),
  .out_sat     (out_sat),
  .bypass_mask (bypass_mask)
);

// File: tb/sim_cplx_pair_combiner.sv
`timescale 1ns/1ps
module sim_cplx_pair_combiner;

  localparam int DW  = 16;
  localparam int NCH = 6;
  localparam int MAXI = (1 << (DW-1)) - 1;
  localparam int MINI = -(1 << (DW-1));

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode_word = 3'b000;
  logic [NCH-1:0]    in_vld = '0;
  logic [NCH*DW-1:0] in_i = '0;
  logic [NCH*DW-1:0] in_q = '0;
  logic [NCH-1:0]    out_vld;
  logic [NCH*DW-1:0] out_i;
  logic [NCH*DW-1:0] out_q;
  logic [NCH-1:0]    out_sat;
  logic [NCH-1:0]    bypass_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected state
  logic [DW-1:0]  ex_i [NCH];
  logic [DW-1:0]  ex_q [NCH];
  logic [NCH-1:0] ex_vld;
  logic [NCH-1:0] ex_sat;
  logic [NCH-1:0] ex_mask;

  always #2.5 clk = ~clk;

  cplx_pair_combiner #(.DW(DW), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .in_vld(in_vld),
    .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_i(out_i),
    .out_q(out_q), .out_sat(out_sat), .bypass_mask(bypass_mask)
  );

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [DW-1:0] clampv(input int v, output bit c);
    c = 1'b0;
    if (v > MAXI) begin c = 1'b1; return DW'(MAXI); end
    if (v < MINI) begin c = 1'b1; return DW'(MINI); end
    return DW'(v);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compute the model's next state from the inputs now driven
  task automatic model_step();
    int npairs = int'(mode_word[1:0]);
    bit c1, c2;
    logic [DW-1:0] ni, nq;
    for (int k = 0; k < NCH; k++) begin
      ex_vld[k] = in_vld[k]; ex_sat[k] = 1'b0; ex_mask[k] = 1'b0;
      if (in_vld[k]) begin
        ex_i[k] = in_i[k*DW +: DW]; ex_q[k] = in_q[k*DW +: DW];
      end
    end
    for (int p = 0; p < NCH/2; p++) begin
      if (p < npairs) begin
        // upper stream: valid dropped, data not loaded
        ex_vld[2*p+1]  = 1'b0;
        ex_mask[2*p+1] = 1'b1;
        if (in_vld[2*p+1]) begin
          ex_i[2*p+1] = out_i[(2*p+1)*DW +: DW];
          ex_q[2*p+1] = out_q[(2*p+1)*DW +: DW];
        end
        ex_vld[2*p] = in_vld[2*p] & in_vld[2*p+1];
        if (mode_word[2]) begin
          ni = in_i[(2*p)*DW +: DW]; nq = in_i[(2*p+1)*DW +: DW];
          c1 = 0; c2 = 0;
        end else begin
          ni = clampv(sx(in_i[(2*p)*DW +: DW]) - sx(in_q[(2*p+1)*DW +: DW]), c1);
          nq = clampv(sx(in_i[(2*p+1)*DW +: DW]) + sx(in_q[(2*p)*DW +: DW]), c2);
        end
        if (ex_vld[2*p]) begin
          ex_i[2*p] = ni; ex_q[2*p] = nq; ex_sat[2*p] = c1 | c2;
        end else begin
          ex_i[2*p] = out_i[(2*p)*DW +: DW]; ex_q[2*p] = out_q[(2*p)*DW +: DW];
        end
      end
    end
  endtask

  task automatic compare_all(input string req);
    for (int k = 0; k < NCH; k++) begin
      chk(req, $sformatf("vld[%0d]", k), longint'(out_vld[k]), longint'(ex_vld[k]));
      chk(req, $sformatf("sat[%0d]", k), longint'(out_sat[k]), longint'(ex_sat[k]));
      chk(req, $sformatf("mask[%0d]", k), longint'(bypass_mask[k]), longint'(ex_mask[k]));
      chk(req, $sformatf("i[%0d]", k), longint'(out_i[k*DW +: DW]), longint'(ex_i[k]));
      chk(req, $sformatf("q[%0d]", k), longint'(out_q[k*DW +: DW]), longint'(ex_q[k]));
    end
  endtask

  // inputs already driven (just after a negedge); result after next posedge
  task automatic run_cycle(input string req);
    model_step();
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic rand_data();
    for (int k = 0; k < NCH; k++) begin
      in_i[k*DW +: DW] = DW'($urandom);
      in_q[k*DW +: DW] = DW'($urandom);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < NCH; k++) begin
      ex_i[k] = '0; ex_q[k] = '0;
    end
    ex_vld = '0; ex_sat = '0; ex_mask = '0;
    mode_word = 3'b011; in_vld = '1; rand_data();
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    in_vld = '0;
    @(negedge clk);
  endtask

  task automatic t_pass();
    for (int n = 0; n < 4; n++) begin
      mode_word = (n % 2 == 0) ? 3'b000 : 3'b100;
      in_vld = NCH'($urandom) | 6'b000001; rand_data();
      run_cycle("R2");
    end
  endtask

  task automatic t_complex();
    for (int w = 1; w < 4; w++) begin
      for (int n = 0; n < 3; n++) begin
        mode_word = 3'(w); in_vld = '1; rand_data();
        run_cycle("R3");
        in_i = {NCH{16'sd100}}; in_q = {NCH{16'sd30}};
        run_cycle("R4");
      end
    end
  endtask

  task automatic t_biphase();
    for (int w = 5; w < 8; w++) begin
      mode_word = 3'(w); in_vld = '1; rand_data();
      run_cycle("R5");
    end
  endtask

  task automatic t_sat();
    mode_word = 3'b011; in_vld = '1;
    // pair0: I = 0x7000 - (-0x7000) clamps high
    in_i[0*DW +: DW] = 16'h7000; in_q[1*DW +: DW] = 16'h9000;
    in_i[1*DW +: DW] = 16'h0001; in_q[0*DW +: DW] = 16'h0002;
    // pair1: Q = -0x8000 + -1 clamps low
    in_i[2*DW +: DW] = 16'h0005; in_q[3*DW +: DW] = 16'h0003;
    in_i[3*DW +: DW] = 16'h8000; in_q[2*DW +: DW] = 16'hFFFF;
    // pair2: exact full scale, no clamp
    in_i[4*DW +: DW] = 16'h7FFE; in_q[5*DW +: DW] = 16'hFFFF;
    in_i[5*DW +: DW] = 16'h0000; in_q[4*DW +: DW] = 16'h8000;
    run_cycle("R6");
    chk("R6", "pair0 sat", longint'(out_sat[0]), 1);
    chk("R6", "pair2 sat", longint'(out_sat[4]), 0);
    mode_word = 3'b111;
    run_cycle("R6");
  endtask

  task automatic t_valid();
    mode_word = 3'b011;
    for (int n = 0; n < 6; n++) begin
      in_vld = NCH'($urandom); rand_data();
      run_cycle("R7");
    end
    mode_word = 3'b001; in_vld = 6'b000010; rand_data();
    run_cycle("R8");
  endtask

  task automatic t_switch();
    for (int n = 0; n < 16; n++) begin
      mode_word = 3'($urandom); in_vld = NCH'($urandom); rand_data();
      run_cycle("R9");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_pass();
    t_complex();
    t_biphase();
    t_sat();
    t_valid();
    t_switch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule